// File: doc/BRIEF.md
# Prioritized Interrupt Flag Controller

This block collects four interrupt sources and turns them into a single interrupt request for a small processor core. The sources are a change on any of three watched port pins, a selectable edge on a fourth pin, a timer overflow pulse and an analog-to-digital conversion-complete pulse. Each source sets a sticky flag. Software reads the flags, clears them and sets them through byte-wide register writes. A flag reaches the core only when its own enable is set. The conversion source must also pass a peripheral group enable. When a global enable is set, the result becomes a request toward a fixed vector address.

The control register holds the three core flags, their three enables, the peripheral group enable and the global enable. The peripheral flag register and the peripheral enable register each implement one bit. When the core accepts the interrupt, the global enable is cleared. A return-from-interrupt strobe sets it again. A wake output reports any enabled pending flag whatever the global enable holds, so a sleeping core can resume without taking the vector. A fixed-priority encoder names the source that should be serviced first.

Top module: `intflag_ctrl`

## Requirements
- R1: A synchronous active-high reset clears all three registers to 8'h00 and holds `wake` and `irq_req` low.
- R2: Control bit 0 (pin-change flag) sets on the clock edge at which any of `pin_in` bits 0, 1 or 3 differs from its value at the previous edge. A change on bit 2 alone leaves bit 0 unchanged.
- R3: Control bit 1 (edge flag) sets on a rising edge of `pin_in[2]` when `ext_rise_sel` is 1, and on a falling edge when it is 0. The opposite edge does not set it.
- R4: A `tmr_ovf` pulse sets control bit 2 (timer flag) at the next edge.
- R5: Only bit 6 of the peripheral flag and peripheral enable registers is implemented, and all other bits read 0 even after a write of 8'hFF. An `adc_done` pulse sets peripheral flag bit 6.
- R6: A write replaces the whole register, so writing 1 sets a flag and writing 0 clears it. A flag with no write stays set. An event in the same cycle as a write of 0 leaves the flag set.
- R7: `wake` is 1 when any of these holds: control bits 0 and 3 are both set, bits 1 and 4 are both set, bits 2 and 5 are both set, or control bit 6, peripheral flag bit 6 and peripheral enable bit 6 are all set. Control bit 7 plays no part.
- R8: `irq_req` equals `wake` AND control bit 7 (global enable), and `vec_addr` reads 004h.
- R9: `accept` clears control bit 7 at the next edge. It overrides a simultaneous `reti` and a simultaneous write.
- R10: `reti` sets control bit 7 at the next edge, even if a control write in the same cycle carries 0 in bit 7.
- R11: `irq_src` names the highest-priority enabled pending source. The codes are 0 for the edge source, 1 for the timer, 2 for the pin change and 3 for the conversion, and the lower code wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 4 | Synchronised port pins; bits 0,1,3 watched for change, bit 2 for edge |
| ext_rise_sel | input | 1 | Edge select for pin 2: 1 rising, 0 falling |
| tmr_ovf | input | 1 | Timer overflow pulse |
| adc_done | input | 1 | Conversion-complete pulse |
| ctl_we | input | 1 | Write strobe for the control register |
| pfl_we | input | 1 | Write strobe for the peripheral flag register |
| pen_we | input | 1 | Write strobe for the peripheral enable register |
| wr_data | input | 8 | Write data shared by the three strobes |
| accept | input | 1 | Core has taken the interrupt |
| reti | input | 1 | Return-from-interrupt strobe |
| ctl_q | output | 8 | Control register contents |
| pfl_q | output | 8 | Peripheral flag register contents |
| pen_q | output | 8 | Peripheral enable register contents |
| wake | output | 1 | Enabled flag pending, independent of global enable |
| irq_req | output | 1 | Interrupt request to the core |
| irq_src | output | 2 | Highest-priority pending source code |
| vec_addr | output | 10 | Interrupt vector address |

## Verification
The hardest cases to reach are the coincidences: an event pulse that lands in the same cycle as a software write clearing its flag, and `accept` arriving together with `reti` or a control write. Directed cycles force each of these collisions once. A long random run then drives overlapping pulses, pin toggles, random writes and acceptances against a bench model. The peripheral group gate is shown by arming the conversion flag and its enable while the group bit is clear and observing `wake` stay low.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
    localparam int REG_W  = 8;
    localparam int PIN_W  = 4;
    localparam int EXT_PIN = 2;
    localparam logic [PIN_W-1:0] CHG_MASK = 4'b1011;

    // control register bit positions
    localparam int B_CHG_F = 0;
    localparam int B_EXT_F = 1;
    localparam int B_TMR_F = 2;
    localparam int B_CHG_E = 3;
    localparam int B_EXT_E = 4;
    localparam int B_TMR_E = 5;
    localparam int B_PER_E = 6;
    localparam int B_GIE   = 7;
    // peripheral registers
    localparam int B_ADC   = 6;
    localparam logic [REG_W-1:0] PER_MASK = 8'h40;

    localparam int NSRC  = 4;
    localparam int SRC_W = $clog2(NSRC);

    typedef enum logic [SRC_W-1:0] {
        SRC_EXT = 0,
        SRC_TMR = 1,
        SRC_CHG = 2,
        SRC_ADC = 3
    } src_e;

    typedef struct packed {
        logic chg;
        logic ext;
        logic tmr;
        logic adc;
    } evt_t;

    // lowest set index wins
    function automatic logic [SRC_W-1:0] first_set(input logic [NSRC-1:0] v);
        logic [SRC_W-1:0] r;
        r = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (v[i]) r = i[SRC_W-1:0];
        end
        return r;
    endfunction
endpackage

// File: rtl/ifc_edge_det.sv
module ifc_edge_det
    import ifc_pkg::*;
#(
    parameter int              W    = PIN_W,
    parameter logic [W-1:0]    MASK = CHG_MASK,
    parameter int              EBIT = EXT_PIN
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_in,
    input  logic         rise_sel,
    output logic         chg_evt,
    output logic         ext_evt
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        prev_q <= pin_in;
    end

    logic rise, fall;
    always_comb begin
        rise    = !prev_q[EBIT] && pin_in[EBIT];
        fall    = prev_q[EBIT] && !pin_in[EBIT];
        chg_evt = !rst && (|((pin_in ^ prev_q) & MASK));
        ext_evt = !rst && (rise_sel ? rise : fall);
    end
endmodule

// File: rtl/ifc_flag_regs.sv
module ifc_flag_regs
    import ifc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  evt_t             evt,
    input  logic             ctl_we,
    input  logic             pfl_we,
    input  logic             pen_we,
    input  logic [REG_W-1:0] wr_data,
    input  logic             accept,
    input  logic             reti,
    output logic [REG_W-1:0] ctl_q,
    output logic [REG_W-1:0] pfl_q,
    output logic [REG_W-1:0] pen_q
);
    logic [REG_W-1:0] ctl_d, pfl_d, pen_d;

    always_comb begin
        ctl_d = ctl_we ? wr_data : ctl_q;
        ctl_d[B_CHG_F] = ctl_d[B_CHG_F] | evt.chg;
        ctl_d[B_EXT_F] = ctl_d[B_EXT_F] | evt.ext;
        ctl_d[B_TMR_F] = ctl_d[B_TMR_F] | evt.tmr;
        if (reti)   ctl_d[B_GIE] = 1'b1;
        if (accept) ctl_d[B_GIE] = 1'b0;

        pfl_d = pfl_we ? wr_data : pfl_q;
        pfl_d[B_ADC] = pfl_d[B_ADC] | evt.adc;
        pfl_d = pfl_d & PER_MASK;

        pen_d = (pen_we ? wr_data : pen_q) & PER_MASK;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            pfl_q <= '0;
            pen_q <= '0;
        end else begin
            ctl_q <= ctl_d;
            pfl_q <= pfl_d;
            pen_q <= pen_d;
        end
    end

    AST_ACCEPT_CLEARS_GIE: assert property (@(posedge clk) disable iff (rst)
        accept |=> !ctl_q[B_GIE]); // R9
    AST_RETI_SETS_GIE: assert property (@(posedge clk) disable iff (rst)
        (reti && !accept) |=> ctl_q[B_GIE]); // R10
    AST_TMR_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (!ctl_we && ctl_q[B_TMR_F]) |=> ctl_q[B_TMR_F]); // R6
    AST_ADC_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        evt.adc |=> pfl_q[B_ADC]); // R5
    AST_TMR_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        evt.tmr |=> ctl_q[B_TMR_F]); // R4
endmodule

// File: rtl/ifc_prio_gate.sv
module ifc_prio_gate
    import ifc_pkg::*;
(
    input  logic [REG_W-1:0] ctl_q,
    input  logic             adc_flag,
    input  logic             adc_en,
    output logic             wake,
    output logic             irq_req,
    output logic [SRC_W-1:0] irq_src
);
    logic [NSRC-1:0] pend;

    always_comb begin
        pend          = '0;
        pend[SRC_EXT] = ctl_q[B_EXT_F] && ctl_q[B_EXT_E];
        pend[SRC_TMR] = ctl_q[B_TMR_F] && ctl_q[B_TMR_E];
        pend[SRC_CHG] = ctl_q[B_CHG_F] && ctl_q[B_CHG_E];
        pend[SRC_ADC] = adc_flag && adc_en && ctl_q[B_PER_E];
        wake          = |pend;
        irq_req       = wake && ctl_q[B_GIE];
        irq_src       = first_set(pend);
    end
endmodule

// File: rtl/intflag_ctrl.sv
module intflag_ctrl
    import ifc_pkg::*;
#(
    parameter int PC_W     = 10,
    parameter int VEC_ADDR = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       pin_in,
    input  logic             ext_rise_sel,
    input  logic             tmr_ovf,
    input  logic             adc_done,
    input  logic             ctl_we,
    input  logic             pfl_we,
    input  logic             pen_we,
    input  logic [7:0]       wr_data,
    input  logic             accept,
    input  logic             reti,
    output logic [7:0]       ctl_q,
    output logic [7:0]       pfl_q,
    output logic [7:0]       pen_q,
    output logic             wake,
    output logic             irq_req,
    output logic [1:0]       irq_src,
    output logic [PC_W-1:0]  vec_addr
);
    localparam logic [PC_W-1:0] VEC = PC_W'(VEC_ADDR);

    logic chg_evt, ext_evt;
    evt_t evt;

    ifc_edge_det #(.W(PIN_W), .MASK(CHG_MASK), .EBIT(EXT_PIN)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .pin_in   (pin_in),
        .rise_sel (ext_rise_sel),
        .chg_evt  (chg_evt),
        .ext_evt  (ext_evt)
    );

    always_comb begin
        evt.chg = chg_evt;
        evt.ext = ext_evt;
        evt.tmr = tmr_ovf;
        evt.adc = adc_done;
    end

    ifc_flag_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .ctl_we  (ctl_we),
        .pfl_we  (pfl_we),
        .pen_we  (pen_we),
        .wr_data (wr_data),
        .accept  (accept),
        .reti    (reti),
        .ctl_q   (ctl_q),
        .pfl_q   (pfl_q),
        .pen_q   (pen_q)
    );

    ifc_prio_gate u_prio (
        .ctl_q    (ctl_q),
        .adc_flag (pfl_q[B_ADC]),
        .adc_en   (pen_q[B_ADC]),
        .wake     (wake),
        .irq_req  (irq_req),
        .irq_src  (irq_src)
    );

    assign vec_addr = VEC;

    AST_REQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> (ctl_q[B_GIE] && wake)); // R8
    AST_EXT_RISE_FLAG: assert property (@(posedge clk) disable iff (rst)
        (ext_rise_sel && !$past(pin_in[EXT_PIN]) && pin_in[EXT_PIN]) |=> ctl_q[B_EXT_F]); // R3
    AST_CHG_FLAG: assert property (@(posedge clk) disable iff (rst)
        (pin_in[3] != $past(pin_in[3])) |=> ctl_q[B_CHG_F]); // R2
    AST_PER_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
        pfl_we |=> ((pfl_q & ~PER_MASK) == '0)); // R5
endmodule

// File: tb/intflag_ctrl_tb.sv
`timescale 1ns/1ps
module intflag_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] pin_in = '0;
    logic       ext_rise_sel = 1'b0;
    logic       tmr_ovf = 1'b0, adc_done = 1'b0;
    logic       ctl_we = 1'b0, pfl_we = 1'b0, pen_we = 1'b0;
    logic [7:0] wr_data = '0;
    logic       accept = 1'b0, reti = 1'b0;
    logic [7:0] ctl_q, pfl_q, pen_q;
    logic       wake, irq_req;
    logic [1:0] irq_src;
    logic [9:0] vec_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] m_ctl, m_pfl, m_pen;
    logic [3:0] m_prev;

    always #2 clk = ~clk;

    intflag_ctrl u_dut (
        .clk(clk), .rst(rst), .pin_in(pin_in), .ext_rise_sel(ext_rise_sel),
        .tmr_ovf(tmr_ovf), .adc_done(adc_done), .ctl_we(ctl_we), .pfl_we(pfl_we),
        .pen_we(pen_we), .wr_data(wr_data), .accept(accept), .reti(reti),
        .ctl_q(ctl_q), .pfl_q(pfl_q), .pen_q(pen_q), .wake(wake),
        .irq_req(irq_req), .irq_src(irq_src), .vec_addr(vec_addr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] pend_of(input logic [7:0] c, input logic [7:0] pf, input logic [7:0] pe);
        pend_of = {c[6] & pf[6] & pe[6], c[0] & c[3], c[2] & c[5], c[1] & c[4]};
    endfunction

    function automatic logic [1:0] src_of(input logic [3:0] p);
        if (p[0]) return 2'd0;
        if (p[1]) return 2'd1;
        if (p[2]) return 2'd2;
        return 2'd3;
    endfunction

    task automatic step_model();
        logic chg, ext;
        logic [7:0] c, pf;
        chg = |((pin_in ^ m_prev) & 4'b1011);
        ext = ext_rise_sel ? (!m_prev[2] && pin_in[2]) : (m_prev[2] && !pin_in[2]);
        if (rst) begin
            m_ctl = '0; m_pfl = '0; m_pen = '0;
        end else begin
            c = ctl_we ? wr_data : m_ctl;
            c[0] = c[0] | chg;
            c[1] = c[1] | ext;
            c[2] = c[2] | tmr_ovf;
            if (reti)   c[7] = 1'b1;
            if (accept) c[7] = 1'b0;
            pf = pfl_we ? wr_data : m_pfl;
            pf[6] = pf[6] | adc_done;
            m_ctl = c;
            m_pfl = pf & 8'h40;
            m_pen = (pen_we ? wr_data : m_pen) & 8'h40;
        end
        m_prev = pin_in;
    endtask

    task automatic compare_all();
        logic [3:0] p;
        p = pend_of(m_ctl, m_pfl, m_pen);
        chk("R6 ctl", ctl_q, m_ctl);
        chk("R5 pfl", pfl_q, m_pfl);
        chk("R5 pen", pen_q, m_pen);
        chk("R7 wake", wake, |p);
        chk("R8 irq_req", irq_req, (|p) & m_ctl[7]);
        if (|p) chk("R11 src", irq_src, src_of(p));
    endtask

    // inputs are driven at a negedge; outputs checked at the following negedge
    task automatic tick();
        step_model();
        @(negedge clk);
        compare_all();
        tmr_ovf = 0; adc_done = 0; ctl_we = 0; pfl_we = 0; pen_we = 0;
        accept = 0; reti = 0; wr_data = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234abcd));
        @(negedge clk);
        tick(); tick();
        // R1 reset state
        chk("R1 ctl", ctl_q, 8'h00);
        chk("R1 pfl", pfl_q, 8'h00);
        chk("R1 pen", pen_q, 8'h00);
        chk("R1 wake", wake, 1'b0);
        chk("R1 irq", irq_req, 1'b0);
        rst = 0;
        tick();

        // R2 bit 2 alone is not a pin change; R3 rising edge
        ext_rise_sel = 1; pin_in = 4'b0100; tick();
        chk("R2 bit2 only", ctl_q[0], 1'b0);
        chk("R3 rising", ctl_q[1], 1'b1);
        pin_in = 4'b1100; tick();
        chk("R2 bit3 change", ctl_q[0], 1'b1);
        ctl_we = 1; wr_data = 8'h00; ext_rise_sel = 0; tick();
        chk("R6 write clears", ctl_q, 8'h00);
        pin_in = 4'b1000; tick();
        chk("R3 falling", ctl_q[1], 1'b1);
        ctl_we = 1; wr_data = 8'h00; tick();
        pin_in = 4'b1100; tick();
        chk("R3 opposite edge", ctl_q[1], 1'b0);
        ctl_we = 1; wr_data = 8'h00; tick();

        // R4 and R6: event beats a write of zero
        ctl_we = 1; wr_data = 8'h00; tmr_ovf = 1; tick();
        chk("R4 R6 event wins", ctl_q, 8'h04);
        ctl_we = 1; wr_data = 8'h20; tick();
        chk("R7 no flag", wake, 1'b0);
        tmr_ovf = 1; tick();
        chk("R7 wake w/o gie", wake, 1'b1);
        chk("R8 no gie", irq_req, 1'b0);
        ctl_we = 1; wr_data = 8'hA4; tick();
        chk("R8 req", irq_req, 1'b1);
        chk("R8 vec", vec_addr, 10'h004);
        chk("R11 tmr", irq_src, 2'd1);
        accept = 1; reti = 1; tick();
        chk("R9 accept wins", ctl_q[7], 1'b0);
        chk("R9 req drop", irq_req, 1'b0);
        reti = 1; ctl_we = 1; wr_data = 8'h24; tick();
        chk("R10 reti", ctl_q[7], 1'b1);
        accept = 1; tick();
        chk("R9 accept", ctl_q, 8'h24);

        // R5 unimplemented bits, R7 group gate, R11 priority
        pfl_we = 1; pen_we = 1; wr_data = 8'hFF; tick();
        chk("R5 pfl mask", pfl_q, 8'h40);
        chk("R5 pen mask", pen_q, 8'h40);
        ctl_we = 1; wr_data = 8'h00; tick();
        chk("R7 group gate", wake, 1'b0);
        ctl_we = 1; wr_data = 8'h40; tick();
        chk("R7 adc wake", wake, 1'b1);
        chk("R11 adc", irq_src, 2'd3);
        ctl_we = 1; wr_data = 8'h76; tick();
        chk("R11 ext first", irq_src, 2'd0);
        ctl_we = 1; wr_data = 8'h6D; tick();
        chk("R11 tmr over chg", irq_src, 2'd1);
        ctl_we = 1; wr_data = 8'h49; tick();
        chk("R11 chg over adc", irq_src, 2'd2);
        pfl_we = 1; wr_data = 8'h00; adc_done = 1; tick();
        chk("R5 adc sets", pfl_q, 8'h40);

        // random phase
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(3) == 0) pin_in = pin_in ^ 4'($urandom());
            if ($urandom_range(15) == 0) ext_rise_sel = ~ext_rise_sel;
            tmr_ovf  = ($urandom_range(7) == 0);
            adc_done = ($urandom_range(7) == 0);
            wr_data  = 8'($urandom());
            ctl_we   = ($urandom_range(5) == 0);
            pfl_we   = ($urandom_range(9) == 0);
            pen_we   = ($urandom_range(9) == 0);
            accept   = irq_req && ($urandom_range(1) == 0);
            reti     = ($urandom_range(7) == 0);
            tick();
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule